// File: doc/BRIEF.md
# Battery Fast-Charge Control Sequencer

This block sequences the charge of a nickel-based battery pack. It reads pre-digitised comparator flags and a timebase tick. The flags say whether the cell voltage is above the maximum-cell level, whether it is above the low-battery level, whether the thermistor reading is above the high-temperature-fault level, and whether it is above the cutoff level. It also takes a slope-termination flag from an external detector, an inhibit input, a power-down flag and a two-bit decoded timer mode. From these it decides when the external current source runs at the full rate, when it only pulses, and what the status lamp shows.

The controller has four states: pending, fast charge, complete/absent and power-down. The safety timer, the hold-off window of the slope detector, the one-second pulse-trickle frame and the half-second lamp blink are all counted in ticks of the timebase. Every duration is a parameter, so a scaled timebase can be used.

Top module: `chg_seq`

## Requirements
- R1: Reset puts the block in the pending state, where the lamp starts lit. A new charge cycle starts, and the block re-enters pending, when `bat_hi_i` was 1 on one clock edge and is 0 on the next edge while the block is in the complete/absent state.
- R2: Pending moves to fast charge on an edge where `bat_hi_i` = 0, `bat_ok_i` = 1, `temp_ok_i` = 1 and `inhibit_i` = 0. Otherwise the block stays pending and pulse-trickles.
- R3: The lamp (`led_o` = 1 means lit) is lit throughout fast charge and dark in complete/absent and power-down. In pending it is lit for SEC_TICKS/2 unpaused ticks, then dark for SEC_TICKS/2 ticks, and repeats.
- R4: From pending, fast charge, or the cycle leaving power-down, `bat_hi_i` = 1 moves the block to complete/absent. It stays there, lamp dark and pulse-trickling, until a new cycle starts.
- R5: Fast charge ends, going to complete/absent, on any of these: `temp_safe_i` = 0; `slope_end_i` = 1 once hold-off is over; or a count of unpaused ticks in fast charge that reaches the selected limit.
- R6: `mode_i` selects the settings. 2'b00: limit LIM_LO_T, hold-off HOLD_LO_T, pulse PW_LO_T. 2'b01 and 2'b11: the MID set. 2'b10: the HI set, and `neg_delta_o` = 1 to ask the detector for negative-delta detection. `neg_delta_o` is 0 for the other codes.
- R7: Outside fast charge and power-down, `charge_o` is 1 for the first pulse-width ticks of each SEC_TICKS-tick frame and 0 for the rest of the frame. The frame counter runs freely from reset and never stops.
- R8: `slope_end_i` is ignored until the fast-charge tick count reaches the hold-off value. Maximum voltage and temperature still end fast charge during hold-off.
- R9: While `inhibit_i` = 1, the safety and hold-off counts and the lamp blink stop, and slope and timeout termination are held off. Fast charge uses pulse-trickle, and temperature and voltage checks stay active. When `inhibit_i` returns to 0, counting resumes from the value it had.
- R10: While `pwr_down_i` = 1 the block is in power-down, with both outputs released (`charge_o` = 1, `led_o` = 0). On the first edge after the flag clears it enters complete/absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| tick_i | input | 1 | One-cycle timebase tick |
| mode_i | input | 2 | Decoded timer-mode select |
| bat_hi_i | input | 1 | Cell voltage above maximum-cell level |
| bat_ok_i | input | 1 | Cell voltage above low-battery level |
| temp_ok_i | input | 1 | Thermistor above high-temperature-fault level |
| temp_safe_i | input | 1 | Thermistor above cutoff level |
| slope_end_i | input | 1 | Slope-termination flag from the detector |
| inhibit_i | input | 1 | Charge inhibit |
| pwr_down_i | input | 1 | Power-down flag |
| charge_o | output | 1 | 1 = charge current enabled (switch released) |
| led_o | output | 1 | 1 = status lamp lit |
| neg_delta_o | output | 1 | 1 = detector uses negative-delta mode |

## Verification
The properties assume that every flag is synchronous to `clk` and already filtered by the comparator front end, so the value seen at an edge is the one acted on. They also assume `tick_i` is a single-cycle pulse. The stimulus changes inputs one nanosecond after a rising edge and generates the tick from a counter with a selectable gap. The mode input is changed only while the block is outside fast charge, so the limit used during a charge stays fixed.

// File: rtl/chg_seq.sv
module chg_seq #(
  parameter int SEC_TICKS  = 1000,
  parameter int PW_LO_T    = 37 * SEC_TICKS / 1000,
  parameter int PW_MID_T   = 73 * SEC_TICKS / 1000,
  parameter int PW_HI_T    = 18 * SEC_TICKS / 1000,
  parameter int HOLD_LO_T  = 150 * SEC_TICKS,
  parameter int HOLD_MID_T = 300 * SEC_TICKS,
  parameter int HOLD_HI_T  = 75 * SEC_TICKS,
  parameter int LIM_LO_T   = 80 * 60 * SEC_TICKS,
  parameter int LIM_MID_T  = 160 * 60 * SEC_TICKS,
  parameter int LIM_HI_T   = 40 * 60 * SEC_TICKS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  input  logic       bat_hi_i,
  input  logic       bat_ok_i,
  input  logic       temp_ok_i,
  input  logic       temp_safe_i,
  input  logic       slope_end_i,
  input  logic       inhibit_i,
  input  logic       pwr_down_i,
  output logic       charge_o,
  output logic       led_o,
  output logic       neg_delta_o
);

  localparam int LIM_MAX = (LIM_LO_T > LIM_MID_T) ?
                           ((LIM_LO_T > LIM_HI_T) ? LIM_LO_T : LIM_HI_T) :
                           ((LIM_MID_T > LIM_HI_T) ? LIM_MID_T : LIM_HI_T);
  localparam int CW   = $clog2(LIM_MAX + 1);
  localparam int TW   = $clog2(SEC_TICKS + 1);
  localparam int HALF = SEC_TICKS / 2;
  localparam int BW   = $clog2(HALF + 1);

  typedef enum logic [1:0] {S_PEND = 2'd0, S_FAST = 2'd1, S_DONE = 2'd2, S_PDN = 2'd3} st_t;

  st_t           st, nxt;
  logic          bat_hi_q;
  logic [TW-1:0] tk;
  logic [BW-1:0] blk;
  logic          ph;
  logic [CW-1:0] fcnt;
  logic [CW-1:0] lim_sel, hold_sel;
  logic [TW-1:0] pw_sel;
  logic          hold_done, time_up, fast_stop;

  always_comb begin
    case (mode_i)
      2'b00: begin lim_sel = CW'(LIM_LO_T); hold_sel = CW'(HOLD_LO_T); pw_sel = TW'(PW_LO_T); end
      2'b10: begin lim_sel = CW'(LIM_HI_T); hold_sel = CW'(HOLD_HI_T); pw_sel = TW'(PW_HI_T); end
      default: begin lim_sel = CW'(LIM_MID_T); hold_sel = CW'(HOLD_MID_T); pw_sel = TW'(PW_MID_T); end
    endcase
  end

  assign hold_done = fcnt >= hold_sel;
  assign time_up   = fcnt >= lim_sel;
  assign fast_stop = bat_hi_i | ~temp_safe_i | (~inhibit_i & ((slope_end_i & hold_done) | time_up));

  always_comb begin
    nxt = st;
    if (pwr_down_i) nxt = S_PDN;
    else begin
      case (st)
        S_PDN:  nxt = S_DONE;
        S_DONE: if (bat_hi_q & ~bat_hi_i) nxt = S_PEND;
        S_PEND: if (bat_hi_i) nxt = S_DONE;
                else if (~inhibit_i & bat_ok_i & temp_ok_i) nxt = S_FAST;
        S_FAST: if (fast_stop) nxt = S_DONE;
        default: nxt = S_PEND;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_PEND;
      bat_hi_q <= 1'b0;
      tk       <= '0;
      blk      <= '0;
      ph       <= 1'b0;
      fcnt     <= '0;
    end else begin
      st       <= nxt;
      bat_hi_q <= bat_hi_i;
      if (tick_i) tk <= (tk == TW'(SEC_TICKS - 1)) ? '0 : tk + 1'b1;
      if (st == S_FAST && nxt == S_FAST) begin
        if (tick_i & ~inhibit_i & ~time_up) fcnt <= fcnt + 1'b1;
      end else fcnt <= '0;
      if (st == S_PEND && nxt == S_PEND) begin
        if (tick_i & ~inhibit_i) begin
          if (blk == BW'(HALF - 1)) begin
            blk <= '0;
            ph  <= ~ph;
          end else blk <= blk + 1'b1;
        end
      end else begin
        blk <= '0;
        ph  <= 1'b0;
      end
    end
  end

  assign led_o       = (st == S_FAST) | (st == S_PEND & ~ph);
  assign charge_o    = (st == S_PDN) | (st == S_FAST & ~inhibit_i) | (tk < pw_sel);
  assign neg_delta_o = (mode_i == 2'b10);

endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pd,
  input logic       bat_hi,
  input logic       temp_safe,
  input logic       slope,
  input logic       inh,
  input logic       led,
  input logic       charge,
  input logic [1:0] st,
  input logic       hold_done,
  input logic       time_up
);
  localparam logic [1:0] PEND = 2'd0, FAST = 2'd1, DONE = 2'd2;

  logic hv, bat_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv       <= 1'b0;
      bat_prev <= 1'b0;
    end else begin
      hv       <= 1'b1;
      bat_prev <= bat_hi;
    end
  end

  p_new_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hv && st == DONE && bat_prev && !bat_hi && !pd) |=> st == PEND);

  p_full_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_hi && !pd) |=> (!led && st == DONE));

  p_temp_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FAST && !temp_safe && !pd) |=> st == DONE);

  p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FAST && slope && !hold_done && !time_up && !bat_hi && temp_safe && !pd) |=> st == FAST);

  p_inh_hold_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FAST && inh && !bat_hi && temp_safe && !pd) |=> st == FAST);

  p_inh_led_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PEND && inh && !bat_hi && !pd) |=> $stable(led));

  p_pdn_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (charge && !led));
endmodule

bind chg_seq chg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd(pwr_down_i), .bat_hi(bat_hi_i), .temp_safe(temp_safe_i),
  .slope(slope_end_i), .inh(inhibit_i), .led(led_o), .charge(charge_o), .st(st),
  .hold_done(hold_done), .time_up(time_up)
);

// File: tb/chg_seq_tb_top.sv
module chg_seq_tb_top;
  localparam int SEC = 20;
  localparam int PWL = 4,  PWM = 7,  PWH = 2;
  localparam int HL  = 30, HM  = 60, HH  = 15;
  localparam int LL  = 120, LM = 240, LH = 60;

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic bat_hi_i = 1'b0, bat_ok_i = 1'b0, temp_ok_i = 1'b1, temp_safe_i = 1'b1;
  logic slope_end_i = 1'b0, inhibit_i = 1'b0, pwr_down_i = 1'b0;
  logic charge_o, led_o, neg_delta_o;

  always #4 clk = ~clk;

  chg_seq #(.SEC_TICKS(SEC), .PW_LO_T(PWL), .PW_MID_T(PWM), .PW_HI_T(PWH),
            .HOLD_LO_T(HL), .HOLD_MID_T(HM), .HOLD_HI_T(HH),
            .LIM_LO_T(LL), .LIM_MID_T(LM), .LIM_HI_T(LH)) dut_i (.*);

  int checks = 0, fails = 0, wd = 0, gap = 1, gcnt = 0;
  bit done = 0;
  string cur = "R1";

  // reference model: 0 pending, 1 fast, 2 complete, 3 power-down
  int m_st = 0, m_tk = 0, m_b = 0, m_f = 0;
  bit m_ph = 0, m_prev = 0;

  function automatic int pw_of(logic [1:0] m);
    return (m == 2'b00) ? PWL : (m == 2'b10) ? PWH : PWM;
  endfunction
  function automatic int hold_of(logic [1:0] m);
    return (m == 2'b00) ? HL : (m == 2'b10) ? HH : HM;
  endfunction
  function automatic int lim_of(logic [1:0] m);
    return (m == 2'b00) ? LL : (m == 2'b10) ? LH : LM;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tk = 0; m_b = 0; m_f = 0; m_ph = 0; m_prev = 0;
    end else begin
      int ns;
      ns = m_st;
      if (pwr_down_i) ns = 3;
      else if (m_st == 3) ns = 2;
      else if (m_st == 2) begin
        if (m_prev && !bat_hi_i) ns = 0;
      end else if (m_st == 0) begin
        if (bat_hi_i) ns = 2;
        else if (!inhibit_i && bat_ok_i && temp_ok_i) ns = 1;
      end else begin
        if (bat_hi_i || !temp_safe_i) ns = 2;
        else if (!inhibit_i && ((slope_end_i && m_f >= hold_of(mode_i)) || m_f >= lim_of(mode_i))) ns = 2;
      end
      if (m_st == 1 && ns == 1) begin
        if (tick_i && !inhibit_i && m_f < lim_of(mode_i)) m_f++;
      end else m_f = 0;
      if (m_st == 0 && ns == 0) begin
        if (tick_i && !inhibit_i) begin
          m_b++;
          if (m_b == SEC / 2) begin m_b = 0; m_ph = !m_ph; end
        end
      end else begin m_b = 0; m_ph = 0; end
      if (tick_i) m_tk = (m_tk + 1) % SEC;
      m_prev = bat_hi_i;
      m_st = ns;
    end
  end

  task automatic chk(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic e_led, e_chg;
      e_led = (m_st == 1) || (m_st == 0 && !m_ph);
      e_chg = (m_st == 3) || (m_st == 1 && !inhibit_i) || (m_tk < pw_of(mode_i));
      chk(cur, "led_o (R3)", led_o, e_led);
      chk(cur, "charge_o (R7)", charge_o, e_chg);
      chk(cur, "neg_delta_o (R6)", neg_delta_o, mode_i == 2'b10);
    end
  end

  always @(posedge clk) begin
    #1;
    gcnt++;
    tick_i = (gcnt % gap == 0);
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic new_cycle();
    bat_hi_i = 1'b1; cyc(2);
    bat_hi_i = 1'b0; cyc(1);
  endtask

  initial begin
    cyc(2);
    chk("R1", "reset led_o", led_o, 1'b1);
    chk("R7", "reset charge_o", charge_o, 1'b1);
    rst_n = 1'b1;
    cur = "R2"; cyc(45);
    chk("R2", "pending led_o phase", led_o, m_ph ? 1'b0 : 1'b1);
    bat_ok_i = 1'b1; cyc(3);
    chk("R2", "fast led_o", led_o, 1'b1);
    cur = "R8"; slope_end_i = 1'b1; cyc(5); slope_end_i = 1'b0;
    chk("R8", "hold-off keeps fast", led_o, 1'b1);
    cyc(40);
    cur = "R5"; slope_end_i = 1'b1; cyc(1); slope_end_i = 1'b0; cyc(2);
    chk("R5", "slope ends fast", led_o, 1'b0);
    cur = "R4"; bat_hi_i = 1'b1; cyc(5);
    temp_ok_i = 1'b0; cur = "R1"; bat_hi_i = 1'b0; cyc(1);
    chk("R1", "new cycle pending lit", led_o, 1'b1);
    cur = "R3"; cyc(30);
    cur = "R9"; inhibit_i = 1'b1; cyc(25); inhibit_i = 1'b0; cyc(7);
    cur = "R2"; temp_ok_i = 1'b1; cyc(10);
    cur = "R9"; inhibit_i = 1'b1; gap = 2; slope_end_i = 1'b1; cyc(30); slope_end_i = 1'b0;
    chk("R9", "inhibit keeps fast", led_o, 1'b1);
    inhibit_i = 1'b0; cyc(5); gap = 1;
    inhibit_i = 1'b1; temp_safe_i = 1'b0; cyc(3);
    chk("R9", "temperature still ends fast under inhibit", led_o, 1'b0);
    temp_safe_i = 1'b1; inhibit_i = 1'b0;
    cur = "R6"; mode_i = 2'b10; new_cycle(); cyc(80);
    chk("R6", "neg_delta_o for code 10", neg_delta_o, 1'b1);
    chk("R5", "timeout ends fast", led_o, 1'b0);
    cur = "R7"; mode_i = 2'b11; cyc(60); mode_i = 2'b01; cyc(40); mode_i = 2'b00; cyc(40);
    cur = "R5"; gap = 3; new_cycle(); cyc(400); gap = 1;
    chk("R5", "timeout with sparse ticks", led_o, 1'b0);
    cur = "R4"; mode_i = 2'b01; new_cycle(); cyc(5); bat_hi_i = 1'b1; cyc(3);
    chk("R4", "maximum voltage in hold-off", led_o, 1'b0);
    cur = "R10"; pwr_down_i = 1'b1; cyc(10);
    chk("R10", "power-down charge_o", charge_o, 1'b1);
    chk("R10", "power-down led_o", led_o, 1'b0);
    pwr_down_i = 1'b0; cyc(25);
    chk("R10", "after power-down lamp dark", led_o, 1'b0);
    cur = "R1"; bat_hi_i = 1'b0; cyc(15);
    chk("R1", "cycle restarts after power-down", led_o, 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule